// File: doc/BRIEF.md
# Four-Channel Burst Memory Copy Engine

This block copies bytes from one memory region to another on behalf of software. It has four channels, and each channel holds a source address, a destination address and a 24-bit byte count. The engine shares a single memory port with a CPU. An internal arbiter decides who owns the port. Whenever the engine wins the port for a channel, it moves a block of bytes and then lets the port go. It keeps competing for the port in this way until that channel's count reaches zero.

Each channel runs in one of two modes. In burst mode, one tenure moves up to 32 bytes. In cycle-steal mode, one tenure moves exactly one byte, so the CPU can take the port back between single bytes. Software starts a channel with one write on the configuration port. It then watches the channel's sticky done flag.

Top module: `bdma_engine`

## Requirements
- R1: After reset, `chan_done` is all zero, `cpu_gnt` is 0 and `mem_en` is 0.
- R2: Each byte beat works as follows.
  - The engine issues a read (`mem_en`=1, `mem_we`=0) at the channel's source address.
  - It waits for `mem_rdy` one cycle later and captures `mem_rdata`.
  - It then issues a write (`mem_en`=1, `mem_we`=1) of that byte at the destination address and waits for `mem_rdy` again.
  - Both addresses then go up by one and the count goes down by one.
  - Only one access is ever outstanding.
  - When a transfer of n bytes is done, destination byte i equals source byte i for every i < n. The byte at destination+n is left untouched.
- R3: In burst mode (`cfg_steal`=0), each bus tenure moves min(remaining, 32) bytes. A transfer of n bytes therefore takes ceil(n/32) tenures, and the last tenure carries n-32*(ceil(n/32)-1) bytes.
- R4: In cycle-steal mode (`cfg_steal`=1), every bus tenure moves exactly one byte.
- R5: After each tenure, the channel withdraws its request for at least one cycle. If the CPU is requesting and no other channel is, the CPU is granted between any two tenures of the same channel.
- R6: Arbitration uses a fixed priority: channel 0 first, then channels 1, 2 and 3, then the CPU. A granted owner keeps the port until its tenure ends. For the CPU, the tenure ends when it drops `cpu_req`.
- R7: `cpu_gnt` is only asserted in the cycle after a cycle in which `cpu_req` was high. It stays asserted while `cpu_req` stays high, and it is never asserted together with `mem_en`.
- R8: A start with a count of zero sets that channel's done flag in the following cycle, and the engine makes no memory access for it.
- R9: A done flag stays set until an accepted start to the same channel. A start with a nonzero count clears the flag in the following cycle.
- R10: A start written to a channel whose transfer is still in progress is ignored. The running transfer completes with its original addresses and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Start strobe for channel `cfg_ch` |
| cfg_ch | input | 2 | Channel index of the start |
| cfg_src | input | 32 | Source start address |
| cfg_dst | input | 32 | Destination start address |
| cfg_cnt | input | 24 | Byte count |
| cfg_steal | input | 1 | Mode: 0 burst, 1 cycle-steal |
| cpu_req | input | 1 | CPU asks for the memory port |
| cpu_gnt | output | 1 | CPU owns the memory port |
| mem_en | output | 1 | Engine access strobe, one cycle per access |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_rdy` |
| mem_rdy | input | 1 | Access completion, one cycle after `mem_en` |
| chan_done | output | 4 | Sticky per-channel done flags |

## Verification
The bench sweeps transfer lengths around the 32-byte tenure boundary (1, 31, 32, 33, 64, 65 and more). It counts the bytes in each tenure from the gaps in port activity. An off-by-one in the burst counter would show up as a 33-byte tenure or an extra 1-byte tenure. The bench also checks a channel that keeps the port instead of yielding, a priority inversion after a CPU tenure, a zero count that touches memory or never finishes, and a restart that corrupts a running transfer. For each of these it looks at tenure counts and order, at CPU grant edges between tenures, and at sentinel bytes around the destination.

// File: rtl/bdma_pkg.sv
// Shared types for the burst copy engine.
package bdma_pkg;
    // Sequencer states: port idle, CPU tenure, read issue/wait, write issue/wait.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CPU,
        ST_RD,
        ST_RDW,
        ST_WR,
        ST_WRW
    } seq_state_t;
endpackage

// File: rtl/bdma_chan.sv
// One channel's register set.
// Holds the source, destination, remaining count and mode, plus the active
// and sticky done flags. A start is taken only while the channel is inactive.
// Assumes step pulses only while the channel owns the port; a start and a step
// therefore never coincide.
module bdma_chan #(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] st_src,
    input  logic [AW-1:0] st_dst,
    input  logic [CW-1:0] st_cnt,
    input  logic          st_mode,
    input  logic          step,
    input  logic          release_i,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt,
    output logic          mode,
    output logic          active,
    output logic          done,
    output logic          req
);
    logic cool;

    // Register update: accept a start, or advance one byte on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src    <= '0;
            dst    <= '0;
            cnt    <= '0;
            mode   <= 1'b0;
            active <= 1'b0;
            done   <= 1'b0;
            cool   <= 1'b0;
        end else begin
            cool <= release_i;
            if (start && !active) begin
                src    <= st_src;
                dst    <= st_dst;
                cnt    <= st_cnt;
                mode   <= st_mode;
                active <= (st_cnt != '0);
                done   <= (st_cnt == '0);
            end else if (step) begin
                src <= src + 1'b1;
                dst <= dst + 1'b1;
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    // Request the port while work remains and no cool-down cycle is pending.
    assign req = active && !cool;
endmodule

// File: rtl/bdma_arb.sv
// Fixed-priority arbiter: the lowest channel index wins, and the CPU wins
// only when no channel requests. It is purely combinational; the sequencer
// samples the result only while the port is idle, which holds a grant.
module bdma_arb #(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input  logic [NCH-1:0] ch_req,
    input  logic           cpu_req,
    output logic           pick_ch,
    output logic [CHW-1:0] pick_idx,
    output logic           pick_cpu
);
    // Scan from the lowest priority upward, so the highest requester lands last.
    always_comb begin
        pick_ch  = 1'b0;
        pick_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (ch_req[i]) begin
                pick_ch  = 1'b1;
                pick_idx = CHW'(i);
            end
        end
    end

    // CPU sits below every channel.
    assign pick_cpu = cpu_req && !pick_ch;
endmodule

// File: rtl/bdma_seq.sv
// Port sequencer.
// Owns the memory port and runs read-then-write byte beats for the selected
// channel. It ends a tenure after BURST beats, after a single beat in steal
// mode, or when the count runs out. It grants the CPU for as long as the CPU
// keeps asking.
// Assumes mem_rdy answers each access, one access at a time.
module bdma_seq
    import bdma_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CHW   = 2,
    parameter int AW    = 32,
    parameter int DW    = 8,
    parameter int CW    = 24,
    parameter int BURST = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pick_ch,
    input  logic [CHW-1:0]         pick_idx,
    input  logic                   pick_cpu,
    input  logic                   cpu_req,
    input  logic [NCH-1:0][AW-1:0] src_v,
    input  logic [NCH-1:0][AW-1:0] dst_v,
    input  logic [NCH-1:0][CW-1:0] cnt_v,
    input  logic [NCH-1:0]         mode_v,
    input  logic [DW-1:0]          mem_rdata,
    input  logic                   mem_rdy,
    output logic [NCH-1:0]         step_v,
    output logic [NCH-1:0]         release_v,
    output logic                   cpu_gnt,
    output logic                   mem_en,
    output logic                   mem_we,
    output logic [AW-1:0]          mem_addr,
    output logic [DW-1:0]          mem_wdata
);
    localparam int BW = $clog2(BURST + 1);

    seq_state_t     state;
    logic [CHW-1:0] owner;
    logic [BW-1:0]  beats;
    logic [DW-1:0]  hold;
    logic           beat_end;
    logic           last_beat;

    // The tenure ends on the final byte, a full burst, or any beat in steal mode.
    assign last_beat = (cnt_v[owner] == CW'(1)) || (beats == BW'(BURST - 1)) || mode_v[owner];
    assign beat_end  = (state == ST_WRW) && mem_rdy;

    // State progression and beat bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            owner <= '0;
            beats <= '0;
            hold  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pick_ch) begin
                        owner <= pick_idx;
                        beats <= '0;
                        state <= ST_RD;
                    end else if (pick_cpu) begin
                        state <= ST_CPU;
                    end
                end
                ST_CPU: if (!cpu_req) state <= ST_IDLE;
                ST_RD:  state <= ST_RDW;
                ST_RDW: begin
                    if (mem_rdy) begin
                        hold  <= mem_rdata;
                        state <= ST_WR;
                    end
                end
                ST_WR:  state <= ST_WRW;
                ST_WRW: begin
                    if (mem_rdy) begin
                        beats <= beats + 1'b1;
                        state <= last_beat ? ST_IDLE : ST_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Per-channel pulses: step on every finished beat, release at tenure end.
    always_comb begin
        step_v    = '0;
        release_v = '0;
        if (beat_end) begin
            step_v[owner] = 1'b1;
            if (last_beat) release_v[owner] = 1'b1;
        end
    end

    // Port drive, decoded from the state.
    assign cpu_gnt   = (state == ST_CPU);
    assign mem_en    = (state == ST_RD) || (state == ST_WR);
    assign mem_we    = (state == ST_WR);
    assign mem_addr  = (state == ST_WR) ? dst_v[owner] : src_v[owner];
    assign mem_wdata = hold;
endmodule

// File: rtl/bdma_engine.sv
// Top of the four-channel burst copy engine.
// Ties the channel register sets, the fixed-priority arbiter and the port
// sequencer together. Only one memory port exists; the CPU shares it through
// cpu_req/cpu_gnt.
module bdma_engine #(
    parameter int NCH   = 4,
    parameter int CHW   = $clog2(NCH),
    parameter int AW    = 32,
    parameter int DW    = 8,
    parameter int CW    = 24,
    parameter int BURST = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [AW-1:0]  cfg_src,
    input  logic [AW-1:0]  cfg_dst,
    input  logic [CW-1:0]  cfg_cnt,
    input  logic           cfg_steal,
    input  logic           cpu_req,
    output logic           cpu_gnt,
    output logic           mem_en,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_rdy,
    output logic [NCH-1:0] chan_done
);
    logic [NCH-1:0][AW-1:0] src_v;
    logic [NCH-1:0][AW-1:0] dst_v;
    logic [NCH-1:0][CW-1:0] cnt_v;
    logic [NCH-1:0]         mode_v;
    logic [NCH-1:0]         chan_active;
    logic [NCH-1:0]         ch_req;
    logic [NCH-1:0]         step_v;
    logic [NCH-1:0]         release_v;
    logic                   pick_ch;
    logic [CHW-1:0]         pick_idx;
    logic                   pick_cpu;

    // One register set per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        bdma_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (cfg_we && (cfg_ch == CHW'(g))),
            .st_src    (cfg_src),
            .st_dst    (cfg_dst),
            .st_cnt    (cfg_cnt),
            .st_mode   (cfg_steal),
            .step      (step_v[g]),
            .release_i (release_v[g]),
            .src       (src_v[g]),
            .dst       (dst_v[g]),
            .cnt       (cnt_v[g]),
            .mode      (mode_v[g]),
            .active    (chan_active[g]),
            .done      (chan_done[g]),
            .req       (ch_req[g])
        );
    end

    bdma_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
        .ch_req   (ch_req),
        .cpu_req  (cpu_req),
        .pick_ch  (pick_ch),
        .pick_idx (pick_idx),
        .pick_cpu (pick_cpu)
    );

    bdma_seq #(
        .NCH(NCH), .CHW(CHW), .AW(AW), .DW(DW), .CW(CW), .BURST(BURST)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pick_ch   (pick_ch),
        .pick_idx  (pick_idx),
        .pick_cpu  (pick_cpu),
        .cpu_req   (cpu_req),
        .src_v     (src_v),
        .dst_v     (dst_v),
        .cnt_v     (cnt_v),
        .mode_v    (mode_v),
        .mem_rdata (mem_rdata),
        .mem_rdy   (mem_rdy),
        .step_v    (step_v),
        .release_v (release_v),
        .cpu_gnt   (cpu_gnt),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );
endmodule

// File: rtl/bdma_engine_chk.sv
// Protocol checker for bdma_engine, attached through bind.
// It watches port exclusivity, access pacing, CPU grant causality and the
// done-flag rules for each channel.
module bdma_engine_chk #(
    parameter int NCH = 4,
    parameter int CHW = 2,
    parameter int CW  = 24
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_we,
    input logic [CHW-1:0] cfg_ch,
    input logic [CW-1:0]  cfg_cnt,
    input logic           cpu_req,
    input logic           cpu_gnt,
    input logic           mem_en,
    input logic           mem_we,
    input logic [NCH-1:0] chan_done,
    input logic [NCH-1:0] chan_active
);
    // R7
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_gnt && mem_en));

    // R7
    cpu_gnt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_gnt |-> $past(cpu_req));

    // R7
    cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_gnt && cpu_req |=> cpu_gnt);

    // R2
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> !mem_en);

    // R2
    read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en && mem_we |-> $past(mem_en, 2) && !$past(mem_we, 2));

    for (genvar g = 0; g < NCH; g++) begin : g_flag
        // R8
        zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_we && cfg_ch == CHW'(g) && cfg_cnt == '0 && !chan_active[g]
            |=> chan_done[g] && !chan_active[g]);

        // R9
        done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            chan_done[g] && !(cfg_we && cfg_ch == CHW'(g)) |=> chan_done[g]);

        // R10
        busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            chan_active[g] && cfg_we && cfg_ch == CHW'(g) |=> chan_active[g] || chan_done[g]);
    end
endmodule

bind bdma_engine bdma_engine_chk #(.NCH(NCH), .CHW(CHW), .CW(CW)) u_bdma_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_ch      (cfg_ch),
    .cfg_cnt     (cfg_cnt),
    .cpu_req     (cpu_req),
    .cpu_gnt     (cpu_gnt),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .chan_done   (chan_done),
    .chan_active (chan_active)
);

// File: tb/test_bdma_engine.sv
module test_bdma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [31:0] cfg_src = '0;
    logic [31:0] cfg_dst = '0;
    logic [23:0] cfg_cnt = '0;
    logic        cfg_steal = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_gnt;
    logic        mem_en;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rdy = 1'b0;
    logic [3:0]  chan_done;

    bdma_engine i_bdma_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt), .cfg_steal(cfg_steal),
        .cpu_req(cpu_req), .cpu_gnt(cpu_gnt), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rdy(mem_rdy), .chan_done(chan_done)
    );

    always #4 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] mem [0:1023];

    // Memory model: answers every access one cycle later.
    always @(posedge clk) begin
        mem_rdy <= rst_n && mem_en;
        if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[9:0]];
        if (mem_en && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    end

    // Monitor state and CPU model control.
    int cpu_mode = 0;      // 0: cpu_req follows cpu_manual, 1: short repeated tenures
    bit cpu_manual = 0;
    int hc = 0;
    int gc = 0;
    int cur_len = 0;
    logic [31:0] cur_first = '0;
    int tn_cnt = 0;
    int tn_max = 0;
    int tn_last = 0;
    int tn_len [0:15];
    logic [31:0] tn_addr [0:15];
    int wr_cnt = 0;
    int en_cnt = 0;
    int cpu_rises = 0;
    int excl_bad = 0;
    logic gnt_q = 1'b0;

    always @(negedge clk) begin
        if (mem_en) begin
            en_cnt++;
            if (mem_we) begin
                if (cur_len == 0) cur_first = mem_addr;
                cur_len++;
                wr_cnt++;
            end
            gc = 0;
        end else begin
            gc++;
            if (gc == 2 && cur_len > 0) begin
                if (tn_cnt < 16) begin
                    tn_len[tn_cnt]  = cur_len;
                    tn_addr[tn_cnt] = cur_first;
                end
                if (cur_len > tn_max) tn_max = cur_len;
                tn_last = cur_len;
                tn_cnt++;
                cur_len = 0;
            end
        end
        if (cpu_gnt && !gnt_q) cpu_rises++;
        gnt_q = cpu_gnt;
        if (cpu_gnt && mem_en) excl_bad++;
        if (cpu_mode == 1) begin
            if (cpu_gnt) begin
                hc++;
                if (hc >= 2) begin
                    cpu_req = 1'b0;
                    hc = 0;
                end
            end else begin
                cpu_req = 1'b1;
            end
        end else begin
            cpu_req = cpu_manual;
        end
    end

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 13 + 5) ^ (k >> 4));
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic mem_init();
        for (int k = 0; k < 1024; k++) mem[k] = (k < 512) ? pat(k) : 8'hEE;
    endtask

    task automatic mon_clear();
        @(posedge clk);
        #1;
        gc = 0; cur_len = 0; tn_cnt = 0; tn_max = 0; tn_last = 0;
        wr_cnt = 0; en_cnt = 0; cpu_rises = 0;
    endtask

    task automatic start(input int ch, input int src, input int dst, input int n, input bit steal);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_src = 32'(src); cfg_dst = 32'(dst);
        cfg_cnt = 24'(n); cfg_steal = steal;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_done(input int ch, input string req);
        int t = 0;
        while (!chan_done[ch] && t < 8000) begin
            @(negedge clk);
            t++;
        end
        chk(chan_done[ch] == 1'b1, req, t, 8000);
        repeat (4) @(negedge clk);
    endtask

    // Copy check: n bytes copied, and the byte after the destination untouched.
    task automatic copy_chk(input int src, input int dst, input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) if (mem[dst + i] != pat(src + i)) bad++;
        chk(bad == 0, req, bad, 0);
        chk(mem[dst + n] == 8'hEE, req, mem[dst + n], 8'hEE);
    endtask

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int lens [8] = '{1, 2, 31, 32, 33, 64, 65, 100};
        mem_init();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(chan_done == 4'b0, "R1 done", chan_done, 0);
        chk(cpu_gnt == 1'b0, "R1 cpu_gnt", cpu_gnt, 0);
        chk(mem_en == 1'b0, "R1 mem_en", mem_en, 0);

        // R2 R3: burst length sweep across the 32-byte boundary
        foreach (lens[j]) begin
            int n = lens[j];
            int src = j * 7;
            int dst = 512 + j * 3;
            int nt = (n + 31) / 32;
            mem_init();
            mon_clear();
            start(j % 4, src, dst, n, 1'b0);
            wait_done(j % 4, "R2 finish");
            copy_chk(src, dst, n, "R2 copy");
            chk(tn_cnt == nt, "R3 tenures", tn_cnt, nt);
            chk(tn_max == ((n < 32) ? n : 32), "R3 max burst", tn_max, (n < 32) ? n : 32);
            chk(tn_last == n - 32 * (nt - 1), "R3 last burst", tn_last, n - 32 * (nt - 1));
        end

        // R4 R5: cycle-steal with a CPU that keeps asking
        for (int n = 1; n <= 7; n += 3) begin
            mem_init();
            cpu_mode = 1;
            mon_clear();
            start(n % 4, 16, 576, n, 1'b1);
            wait_done(n % 4, "R4 finish");
            cpu_mode = 0;
            repeat (4) @(negedge clk);
            copy_chk(16, 576, n, "R4 copy");
            chk(tn_cnt == n, "R4 tenures", tn_cnt, n);
            chk(tn_max == 1, "R4 one byte", tn_max, 1);
            chk(cpu_rises >= n - 1, "R5 cpu between beats", cpu_rises, n - 1);
        end

        // R5: burst mode with a CPU that keeps asking
        mem_init();
        cpu_mode = 1;
        mon_clear();
        start(2, 40, 600, 96, 1'b0);
        wait_done(2, "R5 finish");
        cpu_mode = 0;
        repeat (4) @(negedge clk);
        copy_chk(40, 600, 96, "R5 copy");
        chk(tn_cnt == 3, "R5 tenures", tn_cnt, 3);
        chk(cpu_rises >= 2, "R5 cpu between bursts", cpu_rises, 2);

        // R6 R7: priority after a CPU tenure, and CPU hold
        mem_init();
        cpu_manual = 1;
        repeat (4) @(negedge clk);
        chk(cpu_gnt == 1'b1, "R7 cpu granted", cpu_gnt, 1);
        mon_clear();
        start(1, 100, 768, 10, 1'b0);
        start(0, 0, 512, 40, 1'b0);
        repeat (3) @(negedge clk);
        chk(cpu_gnt == 1'b1 && en_cnt == 0, "R6 R7 cpu keeps port", en_cnt, 0);
        cpu_manual = 0;
        wait_done(0, "R6 finish ch0");
        wait_done(1, "R6 finish ch1");
        chk(tn_cnt == 3, "R6 tenure count", tn_cnt, 3);
        chk(tn_addr[0] == 512 && tn_len[0] == 32, "R6 first ch0", tn_addr[0], 512);
        chk(tn_addr[1] == 768 && tn_len[1] == 10, "R6 then ch1", tn_addr[1], 768);
        chk(tn_addr[2] == 544 && tn_len[2] == 8, "R6 then ch0 tail", tn_addr[2], 544);
        copy_chk(0, 512, 40, "R6 copy ch0");
        copy_chk(100, 768, 10, "R6 copy ch1");
        chk(excl_bad == 0, "R7 exclusive", excl_bad, 0);

        // R8: zero count
        mon_clear();
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'd3; cfg_cnt = '0; cfg_steal = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(chan_done[3] == 1'b1, "R8 done next cycle", chan_done[3], 1);
        repeat (10) @(negedge clk);
        chk(en_cnt == 0, "R8 no access", en_cnt, 0);

        // R9: sticky and cleared by start
        repeat (20) @(negedge clk);
        chk(chan_done[3] == 1'b1, "R9 sticky", chan_done[3], 1);
        chk(chan_done[0] == 1'b1, "R9 sticky ch0", chan_done[0], 1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'd3; cfg_src = 32'd200; cfg_dst = 32'd900; cfg_cnt = 24'd4;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(chan_done[3] == 1'b0, "R9 cleared", chan_done[3], 0);
        wait_done(3, "R9 finish");

        // R10: restart while busy is ignored
        mem_init();
        mon_clear();
        start(2, 0, 512, 50, 1'b0);
        start(2, 256, 800, 5, 1'b1);
        wait_done(2, "R10 finish");
        copy_chk(0, 512, 50, "R10 original copy");
        begin
            int touched = 0;
            for (int i = 0; i < 8; i++) if (mem[800 + i] != 8'hEE) touched++;
            chk(touched == 0, "R10 second dst untouched", touched, 0);
        end
        chk(wr_cnt == 50, "R10 write count", wr_cnt, 50);
        chk(tn_cnt == 2, "R10 original mode", tn_cnt, 2);
        chk(excl_bad == 0, "R7 exclusive end", excl_bad, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule